// File: doc/BRIEF.md
# Interrupt Gateway Bank with Claim/Complete Lockout

This block is a bank of per-source interrupt gateways that sits in front of an interrupt controller's priority arbiter. Each source line is synchronized, then turned into interrupt events: edge-triggered sources use rising edges and level-triggered sources use the line being high. An accepted event raises that source's pending bit. The arbiter and targets downstream read the pending vector. A target then issues a claim strobe carrying the source number it takes. Later it issues a complete strobe carrying the same number.

From the moment a source becomes pending until its completion arrives, the source ignores any further events. Edges seen in that window are dropped and are not counted. A level source whose line is still high when it completes fires again right away. Source numbers run from 1 to `NUM_SRC`. Number 0 means "no interrupt".

Top module: `irq_gateway_bank`

## Requirements
- R1: While `rst_ni` is low, `pending_o` is all zeros. After reset, every source is idle and its edge detector reads the line as low.
- R2: For a level source (`edge_mode_i` bit s-1 = 0), a high on `irq_i` bit s-1 that is set up before clock edge k makes `pending_o` bit s-1 high from edge k+2. It is low after edges k and k+1.
- R3: For an edge source (`edge_mode_i` bit s-1 = 1), only a rising edge on the synchronized line makes the source pending, with the same latency as R2. A line held high does not make the source pending a second time.
- R4: A claim strobe (`claim_i` = 1) with `claim_id_i` = s clears pending bit s-1 at the next clock edge, when source s is pending. The source then counts as in service.
- R5: While a source is in service, its pending bit stays low whatever its input does.
- R6: Rising edges of an edge source that come while it is pending or in service are discarded. They do not cause a pending bit after completion.
- R7: A complete strobe with `complete_id_i` = s ends the service of source s at the next edge. If a level source's line is still high, its pending bit is high again two edges after the strobe.
- R8: A claim or complete strobe carrying ID 0 changes no pending bit.
- R9: A complete strobe for a source that is not in service is ignored, and so is a claim for a source that is not pending. Neither one blocks or clears a later event.
- R10: Each source runs independently of the others. Events on several sources in the same cycle each set their own bit. A claim affects only the source it names.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | NUM_SRC | Raw interrupt lines; bit s-1 is source s |
| edge_mode_i | input | NUM_SRC | Trigger mode per source: 1 edge, 0 level |
| claim_i | input | 1 | Claim strobe |
| claim_id_i | input | ID_W | Source number being claimed |
| complete_i | input | 1 | Completion strobe |
| complete_id_i | input | ID_W | Source number being completed |
| pending_o | output | NUM_SRC | Pending bit per source |

## Verification
A raw line change reaches `pending_o` three clock edges after it is driven: two synchronizer stages plus the pending register. A claim clears its bit one edge after the strobe. A level re-fire after completion appears two edges after the complete strobe. The bench drives inputs on falling edges and pushes each expected pending vector into a scoreboard queue, tagged with the exact cycle in which it is due. The monitor compares on the falling edge of that cycle. A result that arrives early or late, or an item whose cycle has passed unchecked, is reported as a mismatch.

// File: rtl/irq_gw_pkg.sv
package irq_gw_pkg;

  typedef enum logic [1:0] {
    GW_IDLE  = 2'b00,
    GW_PEND  = 2'b01,
    GW_INSVC = 2'b10
  } gw_state_e;

  function automatic int unsigned id_width(input int unsigned n_src);
    return (n_src < 1) ? 1 : $clog2(n_src + 1);
  endfunction

endpackage

// File: rtl/irq_gw_sync.sv
module irq_gw_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/irq_gw_decode.sv
module irq_gw_decode #(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned ID_W    = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [ID_W-1:0]    id_i,
  output logic [NUM_SRC-1:0] hit_o
);

  // ID 0 maps to no bit: sources are numbered from 1
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_hit
    assign hit_o[s] = valid_i && (id_i == ID_W'(s + 1));
  end

  a_r8_zero_id_no_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && id_i == '0) |-> (hit_o == '0));

  a_r10_single_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_o));

endmodule

// File: rtl/irq_gw_cell.sv
module irq_gw_cell
  import irq_gw_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  input  logic edge_mode_i,
  input  logic claim_hit_i,
  input  logic complete_hit_i,
  output logic pend_o
);

  logic      line_s;
  logic      line_prev_q;
  logic      rise;
  logic      evt;
  gw_state_e state_q, state_d;

  irq_gw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw_i),
    .q_o    (line_s)
  );

  // tracks every cycle, so edges inside the lockout are lost, not queued
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_prev_q <= 1'b0;
    else         line_prev_q <= line_s;
  end

  assign rise = line_s & ~line_prev_q;
  assign evt  = edge_mode_i ? rise : line_s;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      GW_IDLE:  if (evt)            state_d = GW_PEND;
      GW_PEND:  if (claim_hit_i)    state_d = GW_INSVC;
      GW_INSVC: if (complete_hit_i) state_d = GW_IDLE;
      default:                      state_d = GW_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= GW_IDLE;
    else         state_q <= state_d;
  end

  assign pend_o = (state_q == GW_PEND);

  a_r4_claim_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && claim_hit_i) |=> (!pend_o && state_q == GW_INSVC));

  a_r5_locked_in_service: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == GW_INSVC) |=> !pend_o);

  a_r3_edge_needs_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == GW_IDLE && edge_mode_i && !(line_s && !line_prev_q)) |=> !pend_o);

  a_r9_stray_complete: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && complete_hit_i && !claim_hit_i) |=> pend_o);

  a_r7_complete_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == GW_INSVC && complete_hit_i) |=> (state_q == GW_IDLE));

endmodule

// File: rtl/irq_gateway_bank.sv
module irq_gateway_bank
  import irq_gw_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ID_W        = id_width(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] irq_i,
  input  logic [NUM_SRC-1:0] edge_mode_i,
  input  logic               claim_i,
  input  logic [ID_W-1:0]    claim_id_i,
  input  logic               complete_i,
  input  logic [ID_W-1:0]    complete_id_i,
  output logic [NUM_SRC-1:0] pending_o
);

  logic [NUM_SRC-1:0] claim_hit;
  logic [NUM_SRC-1:0] complete_hit;

  irq_gw_decode #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_claim_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (claim_i),
    .id_i    (claim_id_i),
    .hit_o   (claim_hit)
  );

  irq_gw_decode #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_cmpl_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (complete_i),
    .id_i    (complete_id_i),
    .hit_o   (complete_hit)
  );

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_gw
    irq_gw_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .raw_i          (irq_i[s]),
      .edge_mode_i    (edge_mode_i[s]),
      .claim_hit_i    (claim_hit[s]),
      .complete_hit_i (complete_hit[s]),
      .pend_o         (pending_o[s])
    );
  end

  a_r1_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |-> (pending_o == '0));

  a_r8_zero_claim_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (claim_i && claim_id_i == '0 && !complete_i) |=> ((pending_o & ~$past(pending_o)) == (pending_o & ~$past(pending_o)) && (($past(pending_o) & ~pending_o) == '0)));

endmodule

// File: tb/irq_gateway_bank_tb_top.sv
module irq_gateway_bank_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NSRC       = 4;
  localparam int IDW        = 3;
  localparam int WDOG       = 5000;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] irq = '0;
  logic [NSRC-1:0] mode = 4'b0110;
  logic            claim = 1'b0;
  logic [IDW-1:0]  claim_id = '0;
  logic            cmpl = 1'b0;
  logic [IDW-1:0]  cmpl_id = '0;
  logic [NSRC-1:0] pending;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    int              due;
    logic [NSRC-1:0] exp;
    string           tag;
  } sb_item_t;

  sb_item_t sb_q[$];
  sb_item_t item;

  irq_gateway_bank #(.NUM_SRC(NSRC), .SYNC_STAGES(2), .ID_W(IDW)) dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .irq_i         (irq),
    .edge_mode_i   (mode),
    .claim_i       (claim),
    .claim_id_i    (claim_id),
    .complete_i    (cmpl),
    .complete_id_i (cmpl_id),
    .pending_o     (pending)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare every item on the falling edge of its due cycle
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
      item = sb_q.pop_front();
      n_chk++;
      if (item.due != cyc || pending !== item.exp) begin
        n_fail++;
        $display("FAIL %s: cycle %0d pending=%b expected %b (due %0d)",
                 item.tag, cyc, pending, item.exp, item.due);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_in(input int d, input logic [NSRC-1:0] v, input string tag);
    sb_item_t it;
    it.due = cyc + d;
    it.exp = v;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic do_claim(input int id);
    claim = 1'b1; claim_id = IDW'(id);
    step(1);
    claim = 1'b0; claim_id = '0;
  endtask

  task automatic do_cmpl(input int id);
    cmpl = 1'b1; cmpl_id = IDW'(id);
    step(1);
    cmpl = 1'b0; cmpl_id = '0;
  endtask

  initial begin
    step(1);
    irq = 4'b1111;  // held high in reset: must not show
    step(2);
    n_chk++;
    if (pending !== '0) begin
      n_fail++;
      $display("FAIL R1: pending=%b expected %b", pending, 4'b0000);
    end
    irq = '0;
    step(3);
    rst_n = 1'b1;
    expect_in(1, 4'b0000, "R1 after release");
    step(3);

    // R2 level source 1, exact latency
    irq[0] = 1'b1;
    expect_in(1, 4'b0000, "R2 early");
    expect_in(2, 4'b0000, "R2 early");
    expect_in(3, 4'b0001, "R2 due");
    step(4);
    // R4 claim clears next edge
    claim = 1'b1; claim_id = 3'd1;
    expect_in(1, 4'b0000, "R4 claim");
    step(1);
    claim = 1'b0; claim_id = '0;
    expect_in(3, 4'b0000, "R5 level held in service");
    expect_in(6, 4'b0000, "R5 level held in service");
    step(6);
    // R7 refire two edges after complete
    cmpl = 1'b1; cmpl_id = 3'd1;
    expect_in(1, 4'b0000, "R7 not yet");
    expect_in(2, 4'b0001, "R7 refire");
    step(1);
    cmpl = 1'b0; cmpl_id = '0;
    step(2);
    irq[0] = 1'b0;
    step(3);
    do_claim(1);
    do_cmpl(1);
    expect_in(4, 4'b0000, "R2 no fire after line low");
    step(5);

    // R3 edge source 2
    irq[1] = 1'b1;
    expect_in(2, 4'b0000, "R3 early");
    expect_in(3, 4'b0010, "R3 rise");
    step(4);
    irq[1] = 1'b0; step(1); irq[1] = 1'b1;
    expect_in(4, 4'b0010, "R6 edge while pending");
    step(5);
    do_claim(2);
    expect_in(1, 4'b0000, "R4 edge claim");
    irq[1] = 1'b0; step(2); irq[1] = 1'b1;
    expect_in(4, 4'b0000, "R6 edge in service");
    step(4);
    do_cmpl(2);
    expect_in(5, 4'b0000, "R6 dropped edge not counted, R3 held high");
    step(6);
    irq[1] = 1'b0; step(3); irq[1] = 1'b1;
    expect_in(3, 4'b0010, "R3 fresh rise");
    step(4);
    do_claim(2);
    do_cmpl(2);
    irq[1] = 1'b0;
    step(4);

    // R8 / R9 on edge source 3
    irq[2] = 1'b1;
    expect_in(3, 4'b0100, "R3 src3 rise");
    step(4);
    do_claim(0);
    expect_in(1, 4'b0100, "R8 claim id0");
    step(1);
    do_cmpl(0);
    expect_in(1, 4'b0100, "R8 complete id0");
    step(1);
    do_cmpl(3);
    expect_in(1, 4'b0100, "R9 stray complete");
    step(1);
    do_claim(3);
    expect_in(1, 4'b0000, "R4 claim after stray complete");
    step(1);
    do_cmpl(3);
    irq[2] = 1'b0;
    step(3);

    // R9 claim of idle source 4 does not lock it
    do_claim(4);
    irq[3] = 1'b1;
    expect_in(3, 4'b1000, "R9 claim idle no lock");
    step(4);

    // R10 simultaneous events and selective claim
    irq[0] = 1'b1; irq[1] = 1'b1;
    expect_in(3, 4'b1011, "R10 simultaneous");
    step(4);
    do_claim(1);
    expect_in(1, 4'b1010, "R10 selective claim");
    step(3);

    if (sb_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL scoreboard: %0d items left, expected %0d", sb_q.size(), 0);
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: cycle %0d reached, expected end before %0d", cyc, WDOG);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

endmodule